// File: doc/BRIEF.md
# Dual-Bus Task Dispatcher

The dispatcher sits between two bus ports and a group of processing engines. One port is the host side and the other is the local side. Each port pushes command words into its own deep write queue. No ready signal slows a burst down; the only flow control is a full flag. Every cycle a round-robin arbiter picks one queue head that can make progress. Plain tasks, read tasks and stream tasks go to the lowest-numbered engine that is idle.

A visibility-update command writes one bit of a sixteen-entry stream table and is never dispatched. A stream task whose stream is marked hidden is dropped without reaching an engine. Every read task leaves a one-bit origin mark in a small in-order queue kept for the engine that took it. When that engine later returns data, the mark steers the data into the read queue of the port that issued the read. The per-port count of outstanding reads is capped, and a read at the head of a queue waits while its port is at the cap.

Top module: `dual_port_task_dispatch`

## Requirements
- R1: After reset no engine strobe is set, both write queues report not full, both read queues report no data, `ret_ready` is high and every stream is marked visible.
- R2: Each write queue is first-in first-out. It accepts one word per cycle, with no stall, until it holds 256 words. It raises its full flag at 256 words, and a word offered while the queue is full is dropped and never dispatched.
- R3: When both queue heads can make progress in the same cycle, the arbiter serves the two ports in alternation. A port that is served without a dispatch (visibility update or dropped task) still counts as served.
- R4: A task goes to the lowest-numbered idle engine. An engine is idle when its busy input is low and it did not receive a task in the previous cycle. At most one engine strobe is high per cycle, and `eng_task_src` gives the port (0 host, 1 local).
- R5: While no engine is idle, the head task waits in its queue and is not lost. It is dispatched once an engine becomes idle.
- R6: Bits [31:30] of a command word hold its opcode: 00 plain task, 01 read task, 10 stream task, 11 visibility update. Bits [19:16] hold the stream ID. For a visibility update, bit 0 is the new visible value (1 visible) for that stream, and the command is consumed without dispatch.
- R7: A stream task whose stream is marked hidden is removed from its queue and never strobed to an engine. Stream tasks for visible streams are dispatched like plain tasks.
- R8: Data returned with `ret_eng` = e goes to the read queue of the port that issued the oldest read still outstanding on engine e. This holds even when engines return out of order relative to each other.
- R9: A port has at most 8 reads outstanding. A read at its head then waits until one of its reads returns, and the other port keeps being served.
- R10: Each read queue output uses valid/ready, and its data holds steady while valid is high and ready is low. `ret_ready` is low while the read queue the pending return is steered to is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_valid | input | 1 | Host port pushes a command word |
| host_wr_data | input | WORD_W | Host command word |
| host_wr_full | output | 1 | Host write queue full |
| loc_wr_valid | input | 1 | Local port pushes a command word |
| loc_wr_data | input | WORD_W | Local command word |
| loc_wr_full | output | 1 | Local write queue full |
| eng_busy | input | N_ENG | Busy status per engine |
| eng_task_valid | output | N_ENG | One-hot task strobe per engine |
| eng_task_word | output | WORD_W | Task word for the strobed engine |
| eng_task_src | output | 1 | Port of the strobed task (0 host, 1 local) |
| ret_valid | input | 1 | Engine read return valid |
| ret_eng | input | clog2(N_ENG) | Engine supplying the return |
| ret_data | input | WORD_W | Returned read data |
| ret_ready | output | 1 | Return accepted this cycle |
| host_rd_valid | output | 1 | Host read queue has data |
| host_rd_data | output | WORD_W | Host read queue head |
| host_rd_ready | input | 1 | Host takes read data |
| loc_rd_valid | output | 1 | Local read queue has data |
| loc_rd_data | output | WORD_W | Local read queue head |
| loc_rd_ready | input | 1 | Local takes read data |

## Verification
The bench fills both queues in the same cycles. A design that keeps one port's priority fixed would serve the same port twice in a row, and the bench checks that the source alternates. It fills the host queue to exactly 256 words behind busy engines and then offers one extra marked word. A design that is off by one in its count would either flag full early or later dispatch the marked word. Two reads on different engines are returned in reverse order, so a design that keeps a single shared origin queue would swap the data between ports. A ninth read tests the outstanding cap, and a local task queued behind it must still pass. The last return is presented against a full host read queue, where a design without that check would drop data.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
    typedef enum logic [1:0] {
        OP_PLAIN  = 2'b00,
        OP_READ   = 2'b01,
        OP_STREAM = 2'b10,
        OP_VIS    = 2'b11
    } op_e;

    localparam int OP_HI  = 31;
    localparam int OP_LO  = 30;
    localparam int SID_LO = 16;
    localparam int VIS_BIT = 0;
endpackage

// File: rtl/tdisp_fifo.sv
module tdisp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_data;
    end

    assign head  = mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/tdisp_pick.sv
module tdisp_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] idle,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        grant = idle & (~idle + N'(1));
        any   = |idle;
    end
endmodule

// File: rtl/dual_port_task_dispatch.sv
module dual_port_task_dispatch
    import tdisp_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int WQ_DEPTH = 256,
    parameter int RQ_DEPTH = 8,
    parameter int MAX_OUT  = 8,
    parameter int N_ENG    = 4,
    parameter int SID_W    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr_valid,
    input  logic [WORD_W-1:0]        host_wr_data,
    output logic                     host_wr_full,
    input  logic                     loc_wr_valid,
    input  logic [WORD_W-1:0]        loc_wr_data,
    output logic                     loc_wr_full,
    input  logic [N_ENG-1:0]         eng_busy,
    output logic [N_ENG-1:0]         eng_task_valid,
    output logic [WORD_W-1:0]        eng_task_word,
    output logic                     eng_task_src,
    input  logic                     ret_valid,
    input  logic [$clog2(N_ENG)-1:0] ret_eng,
    input  logic [WORD_W-1:0]        ret_data,
    output logic                     ret_ready,
    output logic                     host_rd_valid,
    output logic [WORD_W-1:0]        host_rd_data,
    input  logic                     host_rd_ready,
    output logic                     loc_rd_valid,
    output logic [WORD_W-1:0]        loc_rd_data,
    input  logic                     loc_rd_ready
);
    localparam int CW      = $clog2(MAX_OUT + 1);
    localparam int N_SID   = 1 << SID_W;
    localparam int OQ_DEPTH = 2 * MAX_OUT;

    typedef struct packed {
        logic [N_ENG-1:0]       task_v;
        logic [WORD_W-1:0]      task_w;
        logic                   task_src;
        logic                   last;
        logic [N_SID-1:0]       vis;
        logic [1:0][CW-1:0]     outc;
    } disp_st_t;

    disp_st_t st_d, st_q;

    logic              wr_valid [2];
    logic [WORD_W-1:0] wr_data  [2];
    logic [WORD_W-1:0] wq_head  [2];
    logic [1:0]        wq_empty, wq_full, wq_pop;

    logic [1:0]        rq_push, rq_pop, rq_empty, rq_full, rd_ready;
    logic [WORD_W-1:0] rq_head  [2];

    logic [N_ENG-1:0]  oq_push, oq_pop, oq_head, oq_empty, oq_full;

    logic [N_ENG-1:0]  idle, grant;
    logic              any_idle;

    op_e               op  [2];
    logic [SID_W-1:0]  sid [2];
    logic [1:0]        needs_eng, elig;
    logic              sel, go, tgt, ret_acc;
    logic [CW-1:0]     out_host_w, out_loc_w;

    assign wr_valid[0] = host_wr_valid;
    assign wr_valid[1] = loc_wr_valid;
    assign wr_data[0]  = host_wr_data;
    assign wr_data[1]  = loc_wr_data;
    assign rd_ready    = {loc_rd_ready, host_rd_ready};

    for (genvar p = 0; p < 2; p++) begin : g_port
        tdisp_fifo #(.W(WORD_W), .DEPTH(WQ_DEPTH)) u_wq (
            .clk(clk), .rst_n(rst_n),
            .push(wr_valid[p]), .push_data(wr_data[p]),
            .pop(wq_pop[p]), .head(wq_head[p]),
            .empty(wq_empty[p]), .full(wq_full[p])
        );
        tdisp_fifo #(.W(WORD_W), .DEPTH(RQ_DEPTH)) u_rq (
            .clk(clk), .rst_n(rst_n),
            .push(rq_push[p]), .push_data(ret_data),
            .pop(rq_pop[p]), .head(rq_head[p]),
            .empty(rq_empty[p]), .full(rq_full[p])
        );
        assign rq_pop[p] = rd_ready[p] && !rq_empty[p];
    end

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        tdisp_fifo #(.W(1), .DEPTH(OQ_DEPTH)) u_oq (
            .clk(clk), .rst_n(rst_n),
            .push(oq_push[e]), .push_data(sel),
            .pop(oq_pop[e]), .head(oq_head[e]),
            .empty(oq_empty[e]), .full(oq_full[e])
        );
    end

    assign idle = ~eng_busy & ~st_q.task_v;

    tdisp_pick #(.N(N_ENG)) u_pick (
        .idle(idle), .grant(grant), .any(any_idle)
    );

    always_comb begin
        st_d        = st_q;
        st_d.task_v = '0;
        wq_pop      = '0;
        oq_push     = '0;
        oq_pop      = '0;
        rq_push     = '0;

        for (int p = 0; p < 2; p++) begin
            op[p]  = op_e'(wq_head[p][OP_HI:OP_LO]);
            sid[p] = wq_head[p][SID_LO +: SID_W];
            needs_eng[p] = (op[p] == OP_PLAIN) || (op[p] == OP_READ) ||
                           ((op[p] == OP_STREAM) && st_q.vis[sid[p]]);
            elig[p] = !wq_empty[p] &&
                      ((op[p] != OP_READ) || (st_q.outc[p] < CW'(MAX_OUT))) &&
                      (!needs_eng[p] || any_idle);
        end

        sel = (elig[0] && elig[1]) ? ~st_q.last : elig[1];
        go  = |elig;

        if (go) begin
            wq_pop[sel] = 1'b1;
            st_d.last   = sel;
            if (op[sel] == OP_VIS) begin
                st_d.vis[sid[sel]] = wq_head[sel][VIS_BIT];
            end else if (needs_eng[sel]) begin
                st_d.task_v   = grant;
                st_d.task_w   = wq_head[sel];
                st_d.task_src = sel;
                if (op[sel] == OP_READ) begin
                    oq_push          = grant;
                    st_d.outc[sel]   = st_d.outc[sel] + 1'b1;
                end
            end
        end

        tgt       = oq_head[ret_eng];
        ret_ready = oq_empty[ret_eng] || !rq_full[tgt];
        ret_acc   = ret_valid && !oq_empty[ret_eng] && !rq_full[tgt];
        if (ret_acc) begin
            rq_push[tgt]     = 1'b1;
            oq_pop[ret_eng]  = 1'b1;
            st_d.outc[tgt]   = st_d.outc[tgt] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.vis <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_wr_full   = wq_full[0];
    assign loc_wr_full    = wq_full[1];
    assign eng_task_valid = st_q.task_v;
    assign eng_task_word  = st_q.task_w;
    assign eng_task_src   = st_q.task_src;
    assign host_rd_valid  = !rq_empty[0];
    assign host_rd_data   = rq_head[0];
    assign loc_rd_valid   = !rq_empty[1];
    assign loc_rd_data    = rq_head[1];
    assign out_host_w     = st_q.outc[0];
    assign out_loc_w      = st_q.outc[1];
endmodule

// File: rtl/tdisp_chk.sv
module tdisp_chk #(
    parameter int WORD_W  = 32,
    parameter int N_ENG   = 4,
    parameter int MAX_OUT = 8,
    parameter int CW      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_ENG-1:0]  eng_busy,
    input logic [N_ENG-1:0]  eng_task_valid,
    input logic              host_rd_valid,
    input logic              host_rd_ready,
    input logic [WORD_W-1:0] host_rd_data,
    input logic              loc_rd_valid,
    input logic              loc_rd_ready,
    input logic [WORD_W-1:0] loc_rd_data,
    input logic [CW-1:0]     out_host,
    input logic [CW-1:0]     out_loc
);
    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_task_valid));

    // R4
    idle_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_task_valid) |-> ((eng_task_valid & $past(eng_busy)) == '0));

    // R5
    all_busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&$past(eng_busy)) |-> (eng_task_valid == '0));

    // R9
    out_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_host <= CW'(MAX_OUT)) && (out_loc <= CW'(MAX_OUT)));

    // R10
    host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_valid && !host_rd_ready) |=> (host_rd_valid && $stable(host_rd_data)));

    // R10
    loc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd_valid && !loc_rd_ready) |=> (loc_rd_valid && $stable(loc_rd_data)));
endmodule

bind dual_port_task_dispatch tdisp_chk #(
    .WORD_W(WORD_W), .N_ENG(N_ENG), .MAX_OUT(MAX_OUT), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .eng_busy(eng_busy), .eng_task_valid(eng_task_valid),
    .host_rd_valid(host_rd_valid), .host_rd_ready(host_rd_ready), .host_rd_data(host_rd_data),
    .loc_rd_valid(loc_rd_valid), .loc_rd_ready(loc_rd_ready), .loc_rd_data(loc_rd_data),
    .out_host(out_host_w), .out_loc(out_loc_w)
);

// File: tb/dual_port_task_dispatch_bench.sv
`timescale 1ns/1ps
module dual_port_task_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_valid = 1'b0, loc_wr_valid = 1'b0;
    logic [31:0] host_wr_data = '0, loc_wr_data = '0;
    logic        host_wr_full, loc_wr_full;
    logic [3:0]  eng_busy = '0;
    logic [3:0]  eng_task_valid;
    logic [31:0] eng_task_word;
    logic        eng_task_src;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_eng = '0;
    logic [31:0] ret_data = '0;
    logic        ret_ready;
    logic        host_rd_valid, loc_rd_valid;
    logic [31:0] host_rd_data, loc_rd_data;
    logic        host_rd_ready = 1'b0, loc_rd_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int n_disp = 0;
    logic [31:0] log_word [1024];
    logic        log_src  [1024];
    int          log_eng  [1024];

    always #2.5 clk = ~clk;

    dual_port_task_dispatch u_dual_port_task_dispatch (
        .clk(clk), .rst_n(rst_n),
        .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data), .host_wr_full(host_wr_full),
        .loc_wr_valid(loc_wr_valid), .loc_wr_data(loc_wr_data), .loc_wr_full(loc_wr_full),
        .eng_busy(eng_busy), .eng_task_valid(eng_task_valid),
        .eng_task_word(eng_task_word), .eng_task_src(eng_task_src),
        .ret_valid(ret_valid), .ret_eng(ret_eng), .ret_data(ret_data), .ret_ready(ret_ready),
        .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data), .host_rd_ready(host_rd_ready),
        .loc_rd_valid(loc_rd_valid), .loc_rd_data(loc_rd_data), .loc_rd_ready(loc_rd_ready)
    );

    always @(negedge clk) begin
        if (rst_n && (eng_task_valid != '0)) begin
            log_word[n_disp] = eng_task_word;
            log_src[n_disp]  = eng_task_src;
            log_eng[n_disp]  = 0;
            for (int i = 0; i < 4; i++) if (eng_task_valid[i]) log_eng[n_disp] = i;
            n_disp = n_disp + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_host(input logic [31:0] w);
        @(negedge clk);
        host_wr_valid = 1'b1; host_wr_data = w;
        @(negedge clk);
        host_wr_valid = 1'b0;
    endtask

    task automatic push_loc(input logic [31:0] w);
        @(negedge clk);
        loc_wr_valid = 1'b1; loc_wr_data = w;
        @(negedge clk);
        loc_wr_valid = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ret(input int eng, input logic [31:0] d);
        @(negedge clk);
        ret_valid = 1'b1; ret_eng = 2'(eng); ret_data = d;
        for (int i = 0; i < 50; i++) begin
            if (ret_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(eng_task_valid == '0, "R1 strobes", 32'(eng_task_valid), 0);
        chk(!host_wr_full && !loc_wr_full, "R1 full flags", {host_wr_full, loc_wr_full}, 0);
        chk(!host_rd_valid && !loc_rd_valid, "R1 read valid", {host_rd_valid, loc_rd_valid}, 0);
        chk(ret_ready, "R1 ret_ready", 32'(ret_ready), 1);
    endtask

    task automatic t_lowest();
        int base;
        eng_busy = 4'b0000;
        base = n_disp;
        push_host(32'h0000_0011);
        idle_wait(5);
        chk(n_disp == base + 1, "R4 one dispatch", n_disp - base, 1);
        chk(log_eng[base] == 0 && log_src[base] == 1'b0 && log_word[base] == 32'h11,
            "R4 lowest engine 0", 32'(log_eng[base]), 0);
        eng_busy = 4'b0011;
        push_host(32'h0000_0022);
        idle_wait(5);
        chk(log_eng[base+1] == 2 && log_word[base+1] == 32'h22, "R4 skip busy engines",
            32'(log_eng[base+1]), 2);
    endtask

    task automatic t_stall();
        int base;
        eng_busy = 4'b1111;
        base = n_disp;
        push_loc(32'h0000_0033);
        idle_wait(10);
        chk(n_disp == base, "R5 no dispatch while all busy", n_disp - base, 0);
        eng_busy = 4'b0111;
        idle_wait(5);
        chk(n_disp == base + 1 && log_eng[base] == 3 && log_word[base] == 32'h33 && log_src[base] == 1'b1,
            "R5 held task dispatched later", 32'(log_eng[base]), 3);
        eng_busy = 4'b0000;
    endtask

    task automatic t_fair();
        int base;
        bit alt, order;
        base = n_disp;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            host_wr_valid = 1'b1; host_wr_data = 32'h100 + i;
            loc_wr_valid  = 1'b1; loc_wr_data  = 32'h200 + i;
        end
        @(negedge clk);
        host_wr_valid = 1'b0; loc_wr_valid = 1'b0;
        idle_wait(30);
        chk(n_disp == base + 12, "R3 all tasks served", n_disp - base, 12);
        alt = 1'b1;
        for (int i = 1; i < 12; i++) if (log_src[base+i] == log_src[base+i-1]) alt = 1'b0;
        chk(alt, "R3 ports alternate", 32'(alt), 1);
        order = 1'b1;
        for (int i = 0; i < 12; i++) begin
            if (log_src[base+i] == 1'b0 && log_word[base+i] != 32'(32'h100 + i/2)) order = 1'b0;
            if (log_src[base+i] == 1'b1 && log_word[base+i] != 32'(32'h200 + i/2)) order = 1'b0;
        end
        chk(order, "R2 per-port order kept", 32'(order), 1);
    endtask

    task automatic t_vis();
        int base;
        base = n_disp;
        push_host(32'hC005_0000);
        push_host(32'h8005_0ABC);
        idle_wait(15);
        chk(n_disp == base, "R7 hidden stream dropped", n_disp - base, 0);
        push_host(32'h8006_0ABD);
        idle_wait(6);
        chk(n_disp == base + 1 && log_word[base] == 32'h8006_0ABD, "R7 visible stream dispatched",
            log_word[base], 32'h8006_0ABD);
        push_loc(32'hC005_0001);
        push_loc(32'h8005_0ABE);
        idle_wait(6);
        chk(n_disp == base + 2 && log_word[base+1] == 32'h8005_0ABE, "R6 visibility restored",
            log_word[base+1], 32'h8005_0ABE);
    endtask

    task automatic t_read();
        int ea, eb;
        eng_busy = 4'b0000;
        push_host(32'h4000_0001);
        idle_wait(4);
        ea = log_eng[n_disp-1];
        eng_busy = 4'b0001;
        push_loc(32'h4000_0002);
        idle_wait(4);
        eb = log_eng[n_disp-1];
        eng_busy = 4'b0000;
        chk(ea != eb, "R8 reads on two engines", 32'(eb), 1);
        do_ret(eb, 32'hBBBB);
        chk(loc_rd_valid && loc_rd_data == 32'hBBBB && !host_rd_valid, "R8 local data steered",
            loc_rd_data, 32'hBBBB);
        do_ret(ea, 32'hAAAA);
        chk(host_rd_valid && host_rd_data == 32'hAAAA, "R8 host data steered", host_rd_data, 32'hAAAA);
        idle_wait(3);
        chk(host_rd_valid && host_rd_data == 32'hAAAA, "R10 data held without ready",
            host_rd_data, 32'hAAAA);
        host_rd_ready = 1'b1; loc_rd_ready = 1'b1;
        idle_wait(2);
        chk(!host_rd_valid && !loc_rd_valid, "R10 popped on ready", {host_rd_valid, loc_rd_valid}, 0);
        host_rd_ready = 1'b0; loc_rd_ready = 1'b0;
    endtask

    task automatic t_limit();
        int base;
        bit found;
        base = n_disp;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            host_wr_valid = 1'b1; host_wr_data = 32'h4000_0010 + i;
        end
        @(negedge clk);
        host_wr_valid = 1'b0;
        push_loc(32'h0000_0077);
        idle_wait(30);
        chk(n_disp == base + 9, "R9 eight reads plus local task", n_disp - base, 9);
        found = 1'b0;
        for (int i = base; i < n_disp; i++) if (log_word[i] == 32'h4000_0018) found = 1'b1;
        chk(!found, "R9 ninth read held", 32'(found), 0);
        do_ret(log_eng[base], 32'h5000);
        idle_wait(6);
        chk(log_word[n_disp-1] == 32'h4000_0018, "R9 ninth read after return",
            log_word[n_disp-1], 32'h4000_0018);
        for (int i = 1; i < 8; i++) do_ret(log_eng[base+i], 32'h5000 + i);
        @(negedge clk);
        ret_valid = 1'b1; ret_eng = 2'(log_eng[base+9]); ret_data = 32'h5008;
        @(negedge clk);
        chk(!ret_ready, "R10 ret_ready low when read queue full", 32'(ret_ready), 0);
        ret_valid = 1'b0;
        host_rd_ready = 1'b1;
        idle_wait(10);
        do_ret(log_eng[base+9], 32'h5008);
        idle_wait(3);
        host_rd_ready = 1'b0;
    endtask

    task automatic t_full();
        int base;
        bit bad;
        eng_busy = 4'b1111;
        idle_wait(2);
        base = n_disp;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (i == 255) chk(!host_wr_full, "R2 not full at 255", 32'(host_wr_full), 0);
            host_wr_valid = 1'b1; host_wr_data = 32'h1000 + i;
        end
        @(negedge clk);
        chk(host_wr_full, "R2 full at 256", 32'(host_wr_full), 1);
        host_wr_data = 32'h0000_DEAD;
        @(negedge clk);
        host_wr_valid = 1'b0;
        eng_busy = 4'b0000;
        idle_wait(700);
        chk(n_disp == base + 256, "R2 exactly 256 drained", n_disp - base, 256);
        bad = 1'b0;
        for (int i = base; i < n_disp; i++) if (log_word[i] == 32'h0000_DEAD) bad = 1'b1;
        chk(!bad && log_word[n_disp-1] == 32'h10FF, "R2 word offered when full dropped",
            log_word[n_disp-1], 32'h10FF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lowest();
        t_stall();
        t_fair();
        t_vis();
        t_read();
        t_limit();
        t_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule